// File: doc/BRIEF.md
# Four-Phase Instruction Sequencer

This block turns a fast input clock into the timing skeleton of a small pipelined processor. Every input clock belongs to exactly one of four phases, and four consecutive phases form one instruction cycle. The block owns the fetch address and the instruction register, and it raises the data-memory read and write strobes at fixed phases on behalf of the execute logic. It also provides a clock output at one quarter of the input rate.

Fetch and execute overlap. While one instruction sits in the instruction register and executes, the word at the fetch address is read from program memory and captured at the end of the fourth phase. Sequential code therefore completes one instruction per cycle.

When the execute logic reports a taken branch, the block discards the word that was already fetched and executes an empty slot (an all-zero no-operation word). It fetches the branch target during that slot, so a taken branch costs two instruction cycles. Memories are external: program memory returns `pm_data` for `pm_addr`, and data memory acts on `dm_rd` and `dm_wr`.

Top module: `quad_phase_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to phase one, fetch address 0 and an all-zero instruction register, and neither data strobe is active.
- R2: `ph_q` is one-hot at all times. Bit 0 marks phase one and bit 3 marks phase four. The active bit advances by one each input clock, wrapping from bit 3 to bit 0.
- R3: `clk_div4` is high during phases one and two and low during phases three and four.
- R4: `pm_addr` changes only at the clock edge that ends phase one. Without a branch, it takes the value one above the previous fetch address, modulo 2^PC_W.
- R5: `ir` changes only at the clock edge that ends phase four. Without a taken branch, it takes the `pm_data` value for the current fetch address.
- R6: `dm_rd` is high exactly during phase two of a cycle whose `ir` is non-zero.
- R7: `dm_wr` is high exactly during phase four of a cycle whose `ir` is non-zero and whose `wr_req` is high.
- R8: If `br_take` is high during phase four and `ir` is non-zero, then `ir` becomes zero for the next cycle and that cycle fetches from `br_target`. The word at `br_target` executes in the cycle after that, and fetching continues from `br_target`+1.
- R9: `br_take` has no effect in phases one to three, or when `ir` is zero. In those cases `ir` and `pm_addr` follow R4 and R5 unchanged.
- R10: The word at address 0 is in `ir` during the second instruction cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| br_take | input | 1 | Execute logic requests a branch (sampled in phase four) |
| br_target | input | PC_W | Branch destination address |
| wr_req | input | 1 | Executing instruction writes data memory |
| pm_data | input | IW | Program-memory word for `pm_addr` |
| ph_q | output | 4 | One-hot phase strobes, bit 0 = phase one |
| clk_div4 | output | 1 | Input clock divided by four |
| pm_addr | output | PC_W | Program-memory fetch address |
| ir | output | IW | Instruction register, zero means no-operation |
| dm_rd | output | 1 | Data-memory operand read strobe |
| dm_wr | output | 1 | Data-memory destination write strobe |

## Verification
Assertions check on every cycle the properties that hold locally. They cover the phase order and its one-hot shape, the alignment of the divided clock with the phases, fetch-address and instruction-register stability outside their update phases, isolated read strobes, and the flush that follows a taken branch. Only the bench scenarios can show the end-to-end fetch sequence. That includes which memory word reaches the instruction register, where fetching resumes after a branch and after address wrap, that branch requests in the wrong phase or on an empty slot are ignored, and the two-cycle delay before the first instruction after reset.

// File: rtl/qps_pkg.sv
// Package: shared phase type and constants of the four-phase sequencer.
// Assumes one instruction cycle is always exactly four input clocks.
package qps_pkg;
    localparam int unsigned PHASES = 4;
    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;
endpackage

// File: rtl/qps_phase_gen.sv
// Phase generator: counts input clocks modulo four, decodes the count into
// one-hot phase strobes and produces a registered divide-by-four clock.
// Assumes a synchronous active-low reset that starts the count at phase one.
module qps_phase_gen
    import qps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [PHASES-1:0] q,
    output logic              div4
);
    phase_e state;
    logic   div_r;

    // Advance the phase counter once per input clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_Q1;
        end else begin
            unique case (state)
                PH_Q1:   state <= PH_Q2;
                PH_Q2:   state <= PH_Q3;
                PH_Q3:   state <= PH_Q4;
                default: state <= PH_Q1;
            endcase
        end
    end

    // Decode the counter into one strobe per phase.
    for (genvar i = 0; i < PHASES; i++) begin : g_strobe
        assign q[i] = (state == phase_e'(i));
    end

    // Divided clock: drop on entry to phase three, raise on entry to phase one.
    always_ff @(posedge clk) begin
        if (!rst_n)    div_r <= 1'b1;
        else if (q[1]) div_r <= 1'b0;
        else if (q[3]) div_r <= 1'b1;
    end
    assign div4 = div_r;

    for (genvar i = 0; i < PHASES; i++) begin : g_order_chk
        AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            q[i] |=> q[(i + 1) % PHASES]); // R2
    end
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q) == 1); // R2
    AST_DIV_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (q[0] || q[1]) |-> div4); // R3
    AST_DIV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q[2] || q[3]) |-> !div4); // R3
endmodule

// File: rtl/qps_fetch_addr.sv
// Fetch address unit: holds the program counter and the address presented
// to program memory. The fetch address moves only at the end of phase one,
// to the pending branch target if one was recorded in phase four, else to
// the program counter; the program counter then points one beyond it.
// Assumes take_ok is already qualified with phase four and a live instruction.
module qps_fetch_addr #(
    parameter int unsigned PC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ph1,
    input  logic            take_ok,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] fetch_addr
);
    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] tgt_r;
    logic            pend;
    logic [PC_W-1:0] next_fa;

    // Select the next fetch address: the pending target, else the counter.
    always_comb next_fa = pend ? tgt_r : pc;

    // Record a branch in phase four and redirect the fetch at phase one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc         <= '0;
            fetch_addr <= '0;
            tgt_r      <= '0;
            pend       <= 1'b0;
        end else begin
            if (take_ok) begin
                pend  <= 1'b1;
                tgt_r <= target;
            end
            if (ph1) begin
                fetch_addr <= next_fa;
                pc         <= next_fa + PC_W'(1);
                pend       <= 1'b0;
            end
        end
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ph1 |=> $stable(fetch_addr)); // R4
    AST_BRANCH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ph1 && pend) |=> fetch_addr == $past(tgt_r)); // R8
endmodule

// File: rtl/qps_instr_reg.sv
// Instruction register: captures the fetched word at the end of phase four,
// or an all-zero no-operation word when a branch was taken in that phase.
// Assumes pm_data is valid for the current fetch address by phase four.
module qps_instr_reg #(
    parameter int unsigned IW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ph4,
    input  logic          take_ok,
    input  logic [IW-1:0] word_in,
    output logic [IW-1:0] ir_q
);
    // Latch the fetched word, or flush it after a taken branch.
    always_ff @(posedge clk) begin
        if (!rst_n)   ir_q <= '0;
        else if (ph4) ir_q <= take_ok ? '0 : word_in;
    end

    AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ph4 |=> $stable(ir_q)); // R5
    AST_FLUSH_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        take_ok |=> ir_q == '0); // R8
endmodule

// File: rtl/quad_phase_sequencer.sv
// Four-phase fetch/execute sequencer top. Ties the phase generator, fetch
// address unit and instruction register together, qualifies branch requests
// and issues the data-memory strobes at their fixed phases.
// Assumes the execute logic holds br_take, br_target and wr_req valid in
// the phases where they are sampled; an all-zero IR is a no-operation.
module quad_phase_sequencer #(
    parameter int unsigned PC_W = 8,
    parameter int unsigned IW   = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            br_take,
    input  logic [PC_W-1:0] br_target,
    input  logic            wr_req,
    input  logic [IW-1:0]   pm_data,
    output logic [3:0]      ph_q,
    output logic            clk_div4,
    output logic [PC_W-1:0] pm_addr,
    output logic [IW-1:0]   ir,
    output logic            dm_rd,
    output logic            dm_wr
);
    import qps_pkg::*;

    logic [PHASES-1:0] q;
    logic              ir_live;
    logic              take_ok;

    qps_phase_gen u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .q     (q),
        .div4  (clk_div4)
    );

    // Only a real instruction in phase four may redirect the fetch.
    always_comb begin
        ir_live = |ir;
        take_ok = br_take && q[PHASES-1] && ir_live;
    end

    qps_fetch_addr #(.PC_W(PC_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .ph1        (q[0]),
        .take_ok    (take_ok),
        .target     (br_target),
        .fetch_addr (pm_addr)
    );

    qps_instr_reg #(.IW(IW)) u_ir (
        .clk     (clk),
        .rst_n   (rst_n),
        .ph4     (q[PHASES-1]),
        .take_ok (take_ok),
        .word_in (pm_data),
        .ir_q    (ir)
    );

    // Operand read in phase two, destination write in phase four.
    always_comb begin
        ph_q  = q;
        dm_rd = q[1] && ir_live;
        dm_wr = q[PHASES-1] && ir_live && wr_req;
    end

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dm_rd |=> !dm_rd); // R6
    AST_RD_NOT_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        dm_rd |=> !dm_wr); // R7
    AST_WR_IR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        dm_wr |-> $stable(ir)); // R7
endmodule

// File: tb/quad_phase_sequencer_bench.sv
// Bench: directed corner cases plus seeded random instruction cycles,
// compared each phase against a model computed from the requirements.
module quad_phase_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 8;
    localparam int IW   = 14;

    logic            clk;
    logic            rst_n;
    logic            br_take;
    logic [PC_W-1:0] br_target;
    logic            wr_req;
    logic [IW-1:0]   pm_data;
    logic [3:0]      ph_q;
    logic            clk_div4;
    logic [PC_W-1:0] pm_addr;
    logic [IW-1:0]   ir;
    logic            dm_rd;
    logic            dm_wr;

    int n_cmp = 0;
    int n_bad = 0;

    // Model state
    logic [PC_W-1:0] m_pc, m_fa, m_tgt;
    logic            m_pend;
    logic [IW-1:0]   m_ir;

    quad_phase_sequencer #(.PC_W(PC_W), .IW(IW)) u_quad_phase_sequencer (
        .clk(clk), .rst_n(rst_n), .br_take(br_take), .br_target(br_target),
        .wr_req(wr_req), .pm_data(pm_data), .ph_q(ph_q), .clk_div4(clk_div4),
        .pm_addr(pm_addr), .ir(ir), .dm_rd(dm_rd), .dm_wr(dm_wr)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Program memory contents: addresses ending in 5 hold a no-operation.
    function automatic logic [IW-1:0] prog_word(input logic [PC_W-1:0] a);
        if (a[3:0] == 4'd5) return '0;
        return IW'(32'(a) * 32'd2671 + 32'd97);
    endfunction

    // Synchronous program memory model.
    always_ff @(posedge clk) pm_data <= prog_word(pm_addr);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One instruction cycle: per phase drive inputs, check, clock, update model.
    task automatic run_icycle(input bit take, input logic [PC_W-1:0] tgt,
                              input bit wr, input bit noise);
        for (int p = 0; p < 4; p++) begin
            wr_req = wr;
            if (p == 3) begin
                br_take   = take;
                br_target = tgt;
            end else begin
                br_take   = noise;
                br_target = ~tgt;
            end
            #1;
            chk("R2 ph_q", 32'(ph_q), 32'(4'b0001 << p));
            chk("R3 clk_div4", 32'(clk_div4), 32'(p < 2));
            chk("R4 pm_addr", 32'(pm_addr), 32'(m_fa));
            chk("R5 ir", 32'(ir), 32'(m_ir));
            chk("R6 dm_rd", 32'(dm_rd), 32'(p == 1 && m_ir != '0));
            chk("R7 dm_wr", 32'(dm_wr), 32'(p == 3 && m_ir != '0 && wr));
            @(posedge clk);
            if (p == 0) begin
                logic [PC_W-1:0] nxt;
                nxt    = m_pend ? m_tgt : m_pc;
                m_fa   = nxt;
                m_pc   = nxt + PC_W'(1);
                m_pend = 1'b0;
            end
            if (p == 3) begin
                if (take && m_ir != '0) begin
                    m_pend = 1'b1;
                    m_tgt  = tgt;
                    m_ir   = '0;
                end else begin
                    m_ir = prog_word(m_fa);
                end
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        rst_n = 1'b0; br_take = 1'b0; br_target = '0; wr_req = 1'b0;
        m_pc = '0; m_fa = '0; m_tgt = '0; m_pend = 1'b0; m_ir = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 ph_q", 32'(ph_q), 32'h1);
        chk("R1 pm_addr", 32'(pm_addr), 32'h0);
        chk("R1 ir", 32'(ir), 32'h0);
        chk("R1 dm_rd", 32'(dm_rd), 32'h0);
        chk("R1 dm_wr", 32'(dm_wr), 32'h0);
        rst_n = 1'b1;

        // R9: branch request on the empty first slot and in wrong phases is ignored
        run_icycle(1'b1, 8'h40, 1'b1, 1'b1);
        #1 chk("R10 first word", 32'(ir), 32'(prog_word(8'h00)));
        chk("R9 no redirect", 32'(pm_addr), 32'h0);

        // Sequential run, then a branch to 0xF0
        for (int i = 0; i < 3; i++) run_icycle(1'b0, '0, 1'b1, 1'b1);
        if (m_ir == '0) run_icycle(1'b0, '0, 1'b0, 1'b0);
        run_icycle(1'b1, 8'hF0, 1'b0, 1'b0);
        #1 chk("R8 flushed slot", 32'(ir), 32'h0);
        run_icycle(1'b0, '0, 1'b1, 1'b0);
        #1 chk("R8 target word", 32'(ir), 32'(prog_word(8'hF0)));
        chk("R8 target fetched", 32'(pm_addr), 32'hF0);
        run_icycle(1'b0, '0, 1'b0, 1'b0);
        #1 chk("R8 fall-through after target", 32'(pm_addr), 32'hF1);

        // Branch near the top of the address space: fetch wraps to 0 (R4)
        if (m_ir == '0) run_icycle(1'b0, '0, 1'b0, 1'b0);
        run_icycle(1'b1, 8'hFF, 1'b1, 1'b0);
        run_icycle(1'b1, 8'h10, 1'b1, 1'b0);
        run_icycle(1'b0, '0, 1'b0, 1'b0);
        #1 chk("R4 wrap", 32'(pm_addr), 32'h00);

        // Seeded random instruction cycles
        for (int i = 0; i < 400; i++) begin
            run_icycle(($urandom % 4) == 0, PC_W'($urandom), 1'($urandom),
                       1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule